// File: doc/BRIEF.md
# Flash Instruction Prefetch Buffer

This block sits between a processor's instruction-fetch port and a flash array that reads one 128-bit line per access. Each fetch asks for one 16-bit word. The block turns the word address into a line address by dropping the low three bits. It then returns the word that the low bits select from the line. When prefetching is enabled and the read wait-state count is not zero, fetched lines are kept in a two-line store. Words that are already held are returned in the cycle they are asked for. While the processor works through the held words, the next sequential line is read in the background.

A fetch that is neither held nor already being read is treated as a jump. It cancels any read in progress, empties the store and restarts the stream at the target. A fetch outside the flash window is not answered by this block. It empties the store, and no further flash read starts until a fetch lands inside the window again. When the program/erase engine becomes busy, the store is emptied. When prefetching is disabled, or the wait-state count is zero, every fetch becomes one direct flash read and nothing is stored.

Top module: `flash_fetch_prefetch`

## Requirements
- R1: While reset is held low and in the first cycle after it, `if_ack` and `fl_rd` are 0 and the line store is empty.
- R2: A flash read presents line address `if_addr[15:3]` on `fl_line`. The returned `if_word` is bits `[16*k+15:16*k]` of `fl_data`, where `k = if_addr[2:0]`.
- R3: A flash read keeps `fl_rd` high for exactly `rd_wait`+1 cycles, and the data is taken in the last of them. At most one read is in progress.
- R4: With `pf_enable`=0 or `rd_wait`=0, each fetch starts its own flash read and is acknowledged `rd_wait`+1 cycles after the request cycle. A repeated fetch of the same line reads flash again, and no read starts without a request.
- R5: In prefetch mode a fetch of a line that is not held is acknowledged `rd_wait`+2 cycles after the request cycle. A fetch of a held line is acknowledged in the request cycle.
- R6: In prefetch mode, once line L is held the block reads L+1 without being asked, and it holds at most two lines. When a fetch first hits L+1, line L is dropped and L+2 is read ahead.
- R7: A fetch inside flash that hits neither a held line nor the line being read cancels the read in progress, empties the store and starts a read of the target at once. Look-ahead then continues from the target.
- R8: A fetch outside the flash window is not acknowledged. It cancels any read and empties the store, and `fl_rd` stays low until a fetch inside the window arrives.
- R9: No look-ahead read is issued past the top line of the flash window. `fl_line` is always inside the window while `fl_rd` is high.
- R10: A rising edge of `pe_busy` empties the store and stops look-ahead. A fetch that hits in that same cycle is still acknowledged with the held data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pf_enable | input | 1 | Prefetch enable (low selects direct reads) |
| rd_wait | input | 4 | Flash read wait-state count |
| pe_busy | input | 1 | Program/erase engine active |
| if_req | input | 1 | Fetch request, held with the address until acknowledged |
| if_addr | input | 16 | Fetch word address |
| if_ack | output | 1 | Fetch completes this cycle |
| if_word | output | 16 | Fetched instruction word |
| fl_rd | output | 1 | Flash read in progress |
| fl_line | output | 13 | Flash line address |
| fl_data | input | 128 | Flash line data, valid during the read |

## Verification
Two events can land in the same cycle: a buffer hit and the rising edge of the program/erase busy flag. The bench raises `pe_busy` together with a fetch of a held line. It expects that fetch to be answered at once with the correct word. It then expects the following fetch of the other held line to miss, which shows as the full miss latency. A second collision is also provoked: a look-ahead read is still in flight when a jump or an out-of-window fetch arrives. That case is judged by the jump's latency, by the count of flash reads started and by `fl_rd` staying low afterwards.

// File: rtl/fpb_pkg.sv
`timescale 1ns/1ps
// Shared constants and the word selector for the prefetch buffer.
// Assumes a 128-bit flash line made of 16-bit instruction words.
package fpb_pkg;
    localparam int LINE_BITS      = 128;
    localparam int WORD_BITS      = 16;
    localparam int WORDS_PER_LINE = LINE_BITS / WORD_BITS;
    localparam int OFS_BITS       = $clog2(WORDS_PER_LINE);

    // Return the word at offset ofs inside a line.
    function automatic logic [WORD_BITS-1:0] pick_word(
        input logic [LINE_BITS-1:0] line,
        input logic [OFS_BITS-1:0]  ofs
    );
        return line[ofs*WORD_BITS +: WORD_BITS];
    endfunction
endpackage

// File: rtl/fpb_read_timer.sv
`timescale 1ns/1ps
// Flash read sequencer: holds one line read open for wait+1 cycles.
// Assumes flash data is valid while the read is open and is sampled in
// the last cycle (done). A start takes priority over an abort; a start
// while busy restarts the read at the new line.
module fpb_read_timer #(
    parameter int LINE_AW = 13,
    parameter int WAIT_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               abort,
    input  logic [LINE_AW-1:0] start_line,
    input  logic [WAIT_W-1:0]  wait_cfg,
    output logic               busy,
    output logic [LINE_AW-1:0] line_q,
    output logic               done
);
    logic [WAIT_W-1:0] cnt_q;
    logic [WAIT_W-1:0] wq_q;
    logic [WAIT_W:0]   el_q;

    // Open, count down and close the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt_q  <= '0;
            line_q <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            cnt_q  <= wait_cfg;
            line_q <= start_line;
        end else if (abort) begin
            busy   <= 1'b0;
        end else if (busy) begin
            if (cnt_q == '0) busy  <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = busy && (cnt_q == '0);

    // Checker state: wait value at start and cycles spent open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wq_q <= '0;
            el_q <= '0;
        end else if (start) begin
            wq_q <= wait_cfg;
            el_q <= (WAIT_W+1)'(1);
        end else if (busy) begin
            el_q <= el_q + (WAIT_W+1)'(1);
        end
    end

    // R3
    read_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (el_q == ({1'b0, wq_q} + (WAIT_W+1)'(1))));
endmodule

// File: rtl/fpb_line_store.sv
`timescale 1ns/1ps
// Line store: ENTRIES tagged 128-bit lines with lookup by line tag.
// Fills go to the first free entry; the controller only fills when one
// is free. On a consumed hit, any entry that is neither the hit line
// nor the line after it is dropped. Data and tag registers are not reset;
// the valid bits guard them.
module fpb_line_store
    import fpb_pkg::*;
#(
    parameter int LINE_AW = 13,
    parameter int ENTRIES = 2,
    localparam int CW     = $clog2(ENTRIES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [LINE_AW-1:0]   wr_tag,
    input  logic [LINE_BITS-1:0] wr_data,
    input  logic [LINE_AW-1:0]   lk_tag,
    input  logic [OFS_BITS-1:0]  lk_ofs,
    input  logic                 use_en,
    output logic                 hit,
    output logic [WORD_BITS-1:0] rd_word,
    output logic [CW-1:0]        n_valid
);
    logic [ENTRIES-1:0]   vld_q;
    logic [LINE_AW-1:0]   tag_q [ENTRIES];
    logic [LINE_BITS-1:0] dat_q [ENTRIES];
    logic [ENTRIES-1:0]   match, keep, dup, wr_sel;
    logic [LINE_AW-1:0]   lk_next;
    logic [LINE_BITS-1:0] hit_line;
    logic                 wr_dup;

    assign lk_next = lk_tag + LINE_AW'(1);

    // Per-entry compares against the lookup and the write tag.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = vld_q[e] && (tag_q[e] == lk_tag);
        assign keep[e]  = (tag_q[e] == lk_tag) || (tag_q[e] == lk_next);
        assign dup[e]   = vld_q[e] && (tag_q[e] == wr_tag);
    end

    assign hit    = |match;
    assign wr_dup = |dup;

    // Select the hit line and the first free entry, and count valid lines.
    always_comb begin
        logic found;
        hit_line = '0;
        wr_sel   = '0;
        n_valid  = '0;
        found    = 1'b0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (match[e]) hit_line = hit_line | dat_q[e];
            if (!vld_q[e] && !found) begin
                wr_sel[e] = 1'b1;
                found     = 1'b1;
            end
            n_valid = n_valid + CW'(vld_q[e]);
        end
    end

    assign rd_word = pick_word(hit_line, lk_ofs);

    // Valid bits: clear, fill, or drop lines left behind.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            vld_q <= '0;
        end else begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (wr_en && wr_sel[e])
                    vld_q[e] <= 1'b1;
                else if (use_en && hit && vld_q[e] && !keep[e])
                    vld_q[e] <= 1'b0;
            end
        end
    end

    // Tag and data capture on fill.
    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            if (wr_en && wr_sel[e]) begin
                tag_q[e] <= wr_tag;
                dat_q[e] <= wr_data;
            end
        end
    end

    // R6
    fill_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !(&vld_q));
    // R6
    no_dup_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !wr_dup);
endmodule

// File: rtl/flash_fetch_prefetch.sv
`timescale 1ns/1ps
// Flash instruction prefetch buffer (top).
// Serves 16-bit fetches from 128-bit flash lines. In prefetch mode
// (enable set, wait count nonzero) lines are kept in a two-line store
// and the next sequential line is read ahead. Otherwise each fetch is a
// direct read. Assumes the requester holds if_req/if_addr until if_ack,
// and that fl_data reflects fl_line while fl_rd is high.
module flash_fetch_prefetch
    import fpb_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WAIT_W    = 4,
    parameter int ENTRIES   = 2,
    parameter int BASE_LINE = 'h100,
    parameter int NUM_LINES = 'h40,
    localparam int LINE_AW  = ADDR_W - OFS_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pf_enable,
    input  logic [WAIT_W-1:0]    rd_wait,
    input  logic                 pe_busy,
    input  logic                 if_req,
    input  logic [ADDR_W-1:0]    if_addr,
    output logic                 if_ack,
    output logic [WORD_BITS-1:0] if_word,
    output logic                 fl_rd,
    output logic [LINE_AW-1:0]   fl_line,
    input  logic [LINE_BITS-1:0] fl_data
);
    localparam int CW = $clog2(ENTRIES + 1);
    localparam logic [LINE_AW:0] BASE_L = (LINE_AW+1)'(BASE_LINE);
    localparam logic [LINE_AW:0] TOP_L  = (LINE_AW+1)'(BASE_LINE + NUM_LINES - 1);
    localparam logic [CW-1:0]    ENT_L  = CW'(ENTRIES);

    logic [LINE_AW-1:0]   req_line, rd_start_line;
    logic [OFS_BITS-1:0]  req_ofs;
    logic                 in_rng, pf_mode, pe_rise, branch_out, in_flight;
    logic                 pf_hit, pf_miss, kill, dir_start, dir_ack;
    logic                 ahead_ok, pf_start, rd_start, fill, buf_clr;
    logic                 rd_busy, rd_done, buf_hit;
    logic [WORD_BITS-1:0] buf_word;
    logic [CW-1:0]        n_valid;
    logic                 pe_q, pf_live_q;
    logic [LINE_AW:0]     pf_next_q;

    // Fetch decode and mode.
    assign req_line   = if_addr[ADDR_W-1:OFS_BITS];
    assign req_ofs    = if_addr[OFS_BITS-1:0];
    assign in_rng     = ({1'b0, req_line} >= BASE_L) && ({1'b0, req_line} <= TOP_L);
    assign pf_mode    = pf_enable && (rd_wait != '0);
    assign pe_rise    = pe_busy && !pe_q;
    assign branch_out = if_req && !in_rng;
    assign in_flight  = rd_busy && (fl_line == req_line);

    // Prefetch-mode outcomes for the current fetch.
    assign pf_hit  = pf_mode && if_req && in_rng && buf_hit;
    assign pf_miss = pf_mode && if_req && in_rng && !buf_hit && !in_flight;
    assign kill    = pe_rise || branch_out || pf_miss;

    // Read launch: demand (jump or direct) before look-ahead.
    assign dir_start     = !pf_mode && if_req && in_rng && !rd_busy;
    assign ahead_ok      = pf_next_q <= TOP_L;
    assign pf_start      = pf_mode && pf_live_q && !rd_busy && (n_valid < ENT_L)
                           && ahead_ok && !kill;
    assign rd_start      = pf_miss || dir_start || pf_start;
    assign rd_start_line = pf_start ? pf_next_q[LINE_AW-1:0] : req_line;

    // Store fill and clear.
    assign fill    = rd_done && pf_mode && !kill;
    assign buf_clr = kill || !pf_mode;

    // Response to the fetch port.
    assign dir_ack = !pf_mode && rd_done && if_req && in_rng && (fl_line == req_line);
    assign if_ack  = pf_hit || dir_ack;
    assign if_word = pf_hit  ? buf_word :
                     dir_ack ? pick_word(fl_data, req_ofs) : '0;
    assign fl_rd   = rd_busy;

    // Edge detector for the program/erase busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) pe_q <= 1'b0;
        else        pe_q <= pe_busy;
    end

    // Look-ahead stream: restart on a jump, stop on flush, step on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_live_q <= 1'b0;
            pf_next_q <= '0;
        end else if (pf_miss) begin
            pf_live_q <= 1'b1;
            pf_next_q <= {1'b0, req_line} + (LINE_AW+1)'(1);
        end else if (pe_rise || branch_out || !pf_mode) begin
            pf_live_q <= 1'b0;
        end else if (pf_start) begin
            pf_next_q <= pf_next_q + (LINE_AW+1)'(1);
        end
    end

    fpb_read_timer #(
        .LINE_AW (LINE_AW),
        .WAIT_W  (WAIT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (rd_start),
        .abort      (kill),
        .start_line (rd_start_line),
        .wait_cfg   (rd_wait),
        .busy       (rd_busy),
        .line_q     (fl_line),
        .done       (rd_done)
    );

    fpb_line_store #(
        .LINE_AW (LINE_AW),
        .ENTRIES (ENTRIES)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (fill),
        .wr_tag  (fl_line),
        .wr_data (fl_data),
        .lk_tag  (req_line),
        .lk_ofs  (req_ofs),
        .use_en  (pf_hit),
        .hit     (buf_hit),
        .rd_word (buf_word),
        .n_valid (n_valid)
    );

    // R8
    out_range_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        branch_out |=> !fl_rd);
    // R9
    bank_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd |-> (({1'b0, fl_line} >= BASE_L) && ({1'b0, fl_line} <= TOP_L)));
    // R10
    erase_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_rise |=> (n_valid == '0));
    // R4
    bypass_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pf_mode |=> (n_valid == '0));
endmodule

// File: tb/flash_fetch_prefetch_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: fetch() pushes the expected word and checks latency,
// the monitor pops and compares on each acknowledge, and a flash model
// answers reads with a pattern derived from the word address.
module flash_fetch_prefetch_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pf_enable = 1'b0;
    logic [3:0]   rd_wait = 4'd2;
    logic         pe_busy = 1'b0;
    logic         if_req = 1'b0;
    logic [15:0]  if_addr = '0;
    logic         if_ack;
    logic [15:0]  if_word;
    logic         fl_rd;
    logic [12:0]  fl_line;
    logic [127:0] fl_data;

    int total = 0;
    int bad = 0;
    int acc_cnt = 0;
    logic [12:0] last_acc = '0;
    logic        prev_rd = 1'b0;
    logic [12:0] prev_line = '0;
    logic [15:0] exp_q [$];
    bit          ended = 1'b0;

    always #10 clk = ~clk;

    flash_fetch_prefetch u_flash_fetch_prefetch (
        .clk(clk), .rst_n(rst_n), .pf_enable(pf_enable), .rd_wait(rd_wait),
        .pe_busy(pe_busy), .if_req(if_req), .if_addr(if_addr),
        .if_ack(if_ack), .if_word(if_word), .fl_rd(fl_rd),
        .fl_line(fl_line), .fl_data(fl_data)
    );

    function automatic logic [15:0] pat(input logic [15:0] a);
        return a ^ 16'hC35A;
    endfunction

    // Flash array model.
    always_comb begin
        for (int k = 0; k < 8; k++) fl_data[k*16 +: 16] = pat({fl_line, k[2:0]});
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s got=%0h exp=%0h", rq, what, got, exp);
        end
    endtask

    // Monitor: compare each acknowledged word against the scoreboard (R2).
    always @(negedge clk) begin
        #2;
        if (rst_n && if_ack) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected ack word", int'(if_word), 0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(if_word == e, "R2", "ack word", int'(if_word), int'(e));
            end
        end
    end

    // Flash access counter.
    always @(negedge clk) begin
        #2;
        if (fl_rd && (!prev_rd || fl_line != prev_line)) begin
            acc_cnt++;
            last_acc = fl_line;
        end
        prev_rd   = fl_rd;
        prev_line = fl_line;
    end

    // Driver: issue one fetch, leave the request up through its ack cycle.
    task automatic fetch(input logic [15:0] a, input int exp_lat,
                         input string rq, input bit pe = 1'b0);
        int lat;
        @(negedge clk);
        if_req  = 1'b1;
        if_addr = a;
        if (pe) pe_busy = 1'b1;
        exp_q.push_back(pat(a));
        #1;
        lat = 0;
        while (!if_ack && lat < 200) begin
            @(negedge clk);
            #1;
            lat++;
        end
        check(lat == exp_lat, rq, "latency", lat, exp_lat);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        if_req  = 1'b0;
        pe_busy = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (30000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int a0;
        repeat (4) @(negedge clk);
        #2;
        check(if_ack == 1'b0, "R1", "ack in reset", int'(if_ack), 0);
        check(fl_rd == 1'b0, "R1", "fl_rd in reset", int'(fl_rd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(fl_rd == 1'b0, "R1", "fl_rd after reset", int'(fl_rd), 0);

        // R4: direct mode, same line twice reads flash twice.
        rd_wait = 4'd3;
        a0 = acc_cnt;
        fetch(16'h0805, 4, "R4");
        fetch(16'h0806, 4, "R4");
        idle(10);
        check(acc_cnt == a0 + 2, "R4", "direct access count", acc_cnt, a0 + 2);
        check(last_acc == 13'h100, "R2", "line address", int'(last_acc), 'h100);
        // R3: maximum wait count.
        rd_wait = 4'd15;
        fetch(16'h0810, 16, "R3");
        idle(2);
        // R4: wait count zero bypasses even with prefetch enabled.
        rd_wait = 4'd0;
        pf_enable = 1'b1;
        fetch(16'h0811, 1, "R4");
        idle(1);
        a0 = acc_cnt;
        idle(10);
        check(acc_cnt == a0, "R4", "no read without request", acc_cnt, a0);

        // R5/R6: prefetch mode, miss then look-ahead.
        rd_wait = 4'd2;
        idle(2);
        a0 = acc_cnt;
        fetch(16'h0840, 4, "R5");
        idle(20);
        check(acc_cnt == a0 + 2, "R6", "look-ahead one line", acc_cnt, a0 + 2);
        check(last_acc == 13'h109, "R6", "look-ahead line", int'(last_acc), 'h109);
        for (int k = 1; k < 8; k++) fetch(16'h0840 + 16'(k), 0, "R5");
        for (int k = 0; k < 8; k++) fetch(16'h0848 + 16'(k), 0, "R6");
        fetch(16'h0850, 0, "R6");
        idle(20);
        check(acc_cnt == a0 + 4, "R6", "stream access count", acc_cnt, a0 + 4);

        // R7: jump while a look-ahead read is in flight.
        fetch(16'h0880, 4, "R7");
        fetch(16'h08C3, 4, "R7");
        idle(20);
        check(last_acc == 13'h119, "R7", "resume after target", int'(last_acc), 'h119);

        // R8: fetch outside flash during a look-ahead read.
        fetch(16'h0900, 4, "R8");
        @(negedge clk);
        if_addr = 16'h0100;
        @(negedge clk);
        if_req = 1'b0;
        #3;
        a0 = acc_cnt;
        idle(20);
        check(acc_cnt == a0, "R8", "no read after exit", acc_cnt, a0);
        check(fl_rd == 1'b0, "R8", "fl_rd low after exit", int'(fl_rd), 0);
        fetch(16'h0908, 4, "R8");
        idle(5);

        // R9: top of the window.
        fetch(16'h09F0, 4, "R9");
        idle(20);
        check(last_acc == 13'h13F, "R9", "top line fetched", int'(last_acc), 'h13F);
        a0 = acc_cnt;
        fetch(16'h09F8, 0, "R9");
        idle(20);
        check(acc_cnt == a0, "R9", "no read past top", acc_cnt, a0);
        fetch(16'h09FF, 0, "R9");

        // R10: erase start in the same cycle as a hit.
        fetch(16'h0880, 4, "R10");
        idle(20);
        fetch(16'h0881, 0, "R10", 1'b1);
        idle(3);
        fetch(16'h0888, 4, "R10");
        fetch(16'h0889, 0, "R10");
        idle(20);
        @(negedge clk);
        pe_busy = 1'b1;
        idle(2);
        fetch(16'h088A, 4, "R10");
        idle(5);

        check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule